// File: doc/BRIEF.md
# Single-Wire Debug Pin Controller

This block is the target end of a bidirectional debug link that runs over one open-drain wire. It runs on a local debug clock. The host starts every bit by pulling the wire low. The controller passes the wire through a two-flop synchroniser and finds the falling edges on the synchronised level. It then measures how long the wire stays low. A short low is decoded as a received data bit. A low that lasts too long is treated as a SYNC request, and the controller answers it with a low pulse of fixed length.

To send data to the host, a command layer arms one bit through the transmit request. The next host falling edge carries that bit. For a zero, the controller holds the wire low, then drives it high for one cycle to speed up the rising edge, then releases it. For a one, the wire is left to the pull-up. A watchdog on host activity raises a one-cycle soft-reset pulse when the host goes quiet. The command layer uses this pulse to drop the command in progress and to end block transfers. Any armed transmit bit is discarded at the same time.

Top module: `dbg_pin_ctrl`

## Requirements
- R1: While rst is high and in the first cycle after it falls, pin_oe, soft_rst, sync_done and rx_valid are all 0.
- R2: A host low lasting L sampled cycles, with L at most 128, gives exactly one rx_valid pulse one cycle long. The pulse is high after the third rising edge that samples the wire high again. rx_bit is 1 when L < 10 and 0 otherwise.
- R3: A low that is still present on the 129th sampled cycle is a SYNC request. It gives no rx_valid pulse.
- R4: After a SYNC request, the block waits for the rising edge with no time limit, and soft_rst stays 0 for the whole wait.
- R5: Once the wire rises after a SYNC request, the block drives pin_oe=1 and pin_out=0 for exactly 128 cycles, then releases the wire. sync_done is a one-cycle pulse in the first cycle after the release.
- R6: When a pending bit is 0 (tx_req pulsed with tx_bit=0), the next host falling edge makes the block drive pin_out=0 for 13 cycles and then pin_out=1 for one cycle, both with pin_oe=1, and then release the wire. The drive starts after the third rising edge that follows the fall on the wire.
- R7: When a pending bit is 1, the next host falling edge uses up the bit without driving the wire and without producing rx_valid. The host bit after that is received as usual.
- R8: If 512 cycles pass after the last falling edge the block accepted, with no new one, soft_rst pulses for one cycle and any pending transmit bit is discarded. The next host fall is then received as data and is not driven.
- R9: A falling edge inside the 512-cycle window starts the window again.
- R10: soft_rst never pulses unless a falling edge has been accepted since reset or since the last soft_rst.
- R11: pin_oe is 0 except in the SYNC answer and in the transmit-zero drive, and the high speedup drive lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local debug clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Level of the wire, asynchronous to clk |
| pin_out | output | 1 | Value driven onto the wire when enabled |
| pin_oe | output | 1 | Output enable for the wire; the wire is high-impedance when this is 0 |
| tx_req | input | 1 | One-cycle strobe that arms a bit to send to the host |
| tx_bit | input | 1 | Value of the bit armed by tx_req |
| soft_rst | output | 1 | One-cycle pulse when host activity times out |
| sync_done | output | 1 | One-cycle pulse when the SYNC answer ends |
| rx_valid | output | 1 | One-cycle pulse when a received host bit is ready |
| rx_bit | output | 1 | Decoded host bit, valid while rx_valid is high |

## Verification
Host lows of 4, 9, 10, 13 and 128 cycles are used. They separate the two sides of the one-versus-zero threshold and the last data length before SYNC. A low held for several hundred cycles shows that the SYNC wait never times out and that the answer pulse has the right length. Host falls with a pending zero, with a pending one, and after a timeout has thrown the pending bit away check the three transmit paths apart. Gaps between host falls just under and well over the window show when the soft reset fires.

// File: rtl/dbg_pin_pkg.sv
package dbg_pin_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_SYNC_WAIT,
        ST_SYNC_DRV,
        ST_TX_LOW,
        ST_TX_SPD
    } pin_state_e;

    typedef struct packed {
        logic oe;
        logic out;
    } pin_drive_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Wire drive implied by each controller state
    function automatic pin_drive_t drive_of(input pin_state_e s);
        pin_drive_t d;
        case (s)
            ST_SYNC_DRV, ST_TX_LOW: d = '{oe: 1'b1, out: 1'b0};
            ST_TX_SPD:              d = '{oe: 1'b1, out: 1'b1};
            default:                d = '{oe: 1'b0, out: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic lvl,
    output logic fall
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= pin_async;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign lvl  = s2;
    assign fall = s3 & ~s2;
endmodule

// File: rtl/dbg_pin_timeout.sv
module dbg_pin_timeout #(
    parameter int TIMEOUT_CYC = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic halt,
    output logic expire
);
    localparam int TW = $clog2(TIMEOUT_CYC);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

    logic [TW-1:0] tmr;
    logic          armed;

    assign expire = armed && (tmr == T_LAST) && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr   <= '0;
            armed <= 1'b0;
        end else if (restart) begin
            tmr   <= '0;
            armed <= 1'b1;
        end else if (halt) begin
            armed <= 1'b0;
        end else if (armed) begin
            if (tmr == T_LAST) armed <= 1'b0;
            else               tmr   <= tmr + 1'b1;
        end
    end
endmodule

// File: rtl/dbg_pin_ctrl.sv
module dbg_pin_ctrl
    import dbg_pin_pkg::*;
#(
    parameter int SYNC_CYC    = 128,
    parameter int TX_LOW_CYC  = 13,
    parameter int TIMEOUT_CYC = 512,
    parameter int RX_THRESH   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    input  logic tx_req,
    input  logic tx_bit,
    output logic soft_rst,
    output logic sync_done,
    output logic rx_valid,
    output logic rx_bit
);
    localparam int CW = $clog2(imax(SYNC_CYC, TX_LOW_CYC) + 1);
    localparam logic [CW-1:0] SYNC_FULL = CW'(SYNC_CYC);
    localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_CYC - 1);
    localparam logic [CW-1:0] TX_LAST   = CW'(TX_LOW_CYC - 1);
    localparam logic [CW-1:0] RX_THR    = CW'(RX_THRESH);

    pin_state_e    state;
    logic [CW-1:0] cnt;
    logic          pend, pbit;
    logic          lvl, fall, expire, restart, halt;
    pin_drive_t    drv;

    dbg_pin_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pin_in),
        .lvl       (lvl),
        .fall      (fall)
    );

    // Only host falls seen while idle count as activity
    assign restart = (state == ST_IDLE) && fall;
    assign halt    = (state == ST_LOW) && !lvl && (cnt == SYNC_FULL);

    dbg_pin_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .halt    (halt),
        .expire  (expire)
    );

    assign drv     = drive_of(state);
    assign pin_oe  = drv.oe;
    assign pin_out = drv.out;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            pend      <= 1'b0;
            pbit      <= 1'b0;
            soft_rst  <= 1'b0;
            sync_done <= 1'b0;
            rx_valid  <= 1'b0;
            rx_bit    <= 1'b0;
        end else begin
            soft_rst  <= expire;
            sync_done <= 1'b0;
            rx_valid  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (fall) begin
                        if (pend) begin
                            pend <= 1'b0;
                            if (!pbit) begin
                                state <= ST_TX_LOW;
                                cnt   <= '0;
                            end
                        end else begin
                            state <= ST_LOW;
                            cnt   <= CW'(1);
                        end
                    end
                end
                ST_LOW: begin
                    if (lvl) begin
                        rx_valid <= 1'b1;
                        rx_bit   <= (cnt < RX_THR);
                        state    <= ST_IDLE;
                    end else if (cnt == SYNC_FULL) begin
                        state <= ST_SYNC_WAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SYNC_WAIT: begin
                    if (lvl) begin
                        state <= ST_SYNC_DRV;
                        cnt   <= '0;
                    end
                end
                ST_SYNC_DRV: begin
                    if (cnt == SYNC_LAST) begin
                        state     <= ST_IDLE;
                        sync_done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TX_LOW: begin
                    if (cnt == TX_LAST) state <= ST_TX_SPD;
                    else                cnt   <= cnt + 1'b1;
                end
                ST_TX_SPD: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
            if (tx_req) begin
                pend <= 1'b1;
                pbit <= tx_bit;
            end
            if (expire) begin
                state <= ST_IDLE;
                pend  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dbg_pin_ctrl_chk.sv
module dbg_pin_ctrl_chk #(
    parameter int SYNC_CYC   = 128,
    parameter int TX_LOW_CYC = 13
) (
    input logic clk,
    input logic rst,
    input logic pin_oe,
    input logic pin_out,
    input logic soft_rst,
    input logic sync_done,
    input logic rx_valid
);
    localparam int RW = $clog2(SYNC_CYC + 2);
    localparam logic [RW-1:0] RUN_SYNC = RW'(SYNC_CYC);
    localparam logic [RW-1:0] RUN_TX   = RW'(TX_LOW_CYC);

    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)                   run <= '0;
        else if (pin_oe && !pin_out) run <= run + 1'b1;
        else                       run <= '0;
    end

    // R5
    sync_len_chk: assert property (@(posedge clk) disable iff (rst)
        sync_done |-> (run == RUN_SYNC) && !pin_oe);

    // R5
    drive_cap_chk: assert property (@(posedge clk) disable iff (rst)
        run <= RUN_SYNC);

    // R6
    spd_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && pin_out) |-> (run == RUN_TX));

    // R11
    spd_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && pin_out) |=> !pin_oe);

    // R8
    soft_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !soft_rst);

    // R8
    soft_idle_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> !pin_oe);

    // R2
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind dbg_pin_ctrl dbg_pin_ctrl_chk #(
    .SYNC_CYC   (SYNC_CYC),
    .TX_LOW_CYC (TX_LOW_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .soft_rst  (soft_rst),
    .sync_done (sync_done),
    .rx_valid  (rx_valid)
);

// File: tb/dbg_pin_ctrl_test.sv
`timescale 1ns/1ps
module dbg_pin_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_low = 1'b0;
    logic tx_req = 1'b0, tx_bit = 1'b0;
    logic pin_in, pin_out, pin_oe, soft_rst, sync_done, rx_valid, rx_bit;
    int   errors = 0, checks = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign pin_in = ~(host_low | (pin_oe & ~pin_out));

    dbg_pin_ctrl uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .tx_req(tx_req), .tx_bit(tx_bit), .soft_rst(soft_rst), .sync_done(sync_done),
        .rx_valid(rx_valid), .rx_bit(rx_bit)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: wire history and phase timers
    bit d1 = 1, d2 = 1, d3 = 1;
    int m_ph = 0;       // 0 idle, 1 host low, 2 sync wait, 3 sync answer, 4 tx low, 5 speedup
    int m_low = 0, m_left = 0, m_since = 0;
    bit m_watch = 0, m_pend = 0, m_pval = 0;
    bit e_oe = 0, e_out = 0, e_soft = 0, e_sd = 0, e_rxv = 0, e_rxb = 0;

    always @(posedge clk) begin
        bit wire_now, fell, fired;
        wire_now = !(host_low || (e_oe && !e_out));
        if (rst) begin
            d1 = 1; d2 = 1; d3 = 1; m_ph = 0; m_watch = 0; m_pend = 0;
            e_soft = 0; e_sd = 0; e_rxv = 0; e_rxb = 0;
        end else begin
            fell = d3 && !d2;
            fired = 0;
            e_sd = 0; e_rxv = 0;
            if (m_ph == 0 && fell) begin
                m_since = 0; m_watch = 1;
            end else if (m_watch) begin
                if (m_since == 511) begin fired = 1; m_watch = 0; end
                else m_since++;
            end
            if (m_ph == 0) begin
                if (fell) begin
                    if (m_pend) begin
                        m_pend = 0;
                        if (!m_pval) begin m_ph = 4; m_left = 13; end
                    end else begin
                        m_ph = 1; m_low = 1;
                    end
                end
            end else if (m_ph == 1) begin
                if (d2) begin e_rxv = 1; e_rxb = (m_low < 10); m_ph = 0; end
                else if (m_low >= 128) begin m_ph = 2; m_watch = 0; end
                else m_low++;
            end else if (m_ph == 2) begin
                if (d2) begin m_ph = 3; m_left = 128; end
            end else if (m_ph == 3) begin
                m_left--;
                if (m_left == 0) begin m_ph = 0; e_sd = 1; end
            end else if (m_ph == 4) begin
                m_left--;
                if (m_left == 0) m_ph = 5;
            end else begin
                m_ph = 0;
            end
            if (tx_req) begin m_pend = 1; m_pval = tx_bit; end
            if (fired) begin m_ph = 0; m_pend = 0; end
            e_soft = fired;
        end
        e_oe  = (m_ph >= 3);
        e_out = (m_ph == 5);
        d3 = d2; d2 = d1; d1 = wire_now;
    end

    // Per-cycle comparison and port monitor
    int n_rx = 0, n_rx1 = 0, n_soft = 0, n_sd = 0, n_low = 0, n_spd = 0;
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (pin_oe !== e_oe || (e_oe && pin_out !== e_out)) begin
                errors++;
                $display("FAIL R11 drive oe/out actual=%0b%0b expected=%0b%0b", pin_oe, pin_out, e_oe, e_out);
            end
            if (soft_rst !== e_soft) begin
                errors++;
                $display("FAIL R8 soft_rst actual=%0b expected=%0b", soft_rst, e_soft);
            end
            if (sync_done !== e_sd) begin
                errors++;
                $display("FAIL R5 sync_done actual=%0b expected=%0b", sync_done, e_sd);
            end
            if (rx_valid !== e_rxv || (e_rxv && rx_bit !== e_rxb)) begin
                errors++;
                $display("FAIL R2 rx actual=%0b/%0b expected=%0b/%0b", rx_valid, rx_bit, e_rxv, e_rxb);
            end
            if (rx_valid) begin n_rx++; if (rx_bit) n_rx1++; end
            if (soft_rst) n_soft++;
            if (sync_done) n_sd++;
            if (pin_oe && !pin_out) n_low++;
            if (pin_oe && pin_out) n_spd++;
        end
    end

    task automatic clr_mon();
        @(negedge clk);
        n_rx = 0; n_rx1 = 0; n_soft = 0; n_sd = 0; n_low = 0; n_spd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_pulse(input int len, input int gap);
        @(negedge clk);
        host_low = 1'b1;
        repeat (len) @(negedge clk);
        host_low = 1'b0;
        idle(gap);
    endtask

    task automatic arm(input logic b);
        @(negedge clk);
        tx_req = 1'b1; tx_bit = b;
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1", "pin_oe in reset", int'(pin_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "outputs after reset", int'({pin_oe, soft_rst, sync_done, rx_valid}), 0);

        // R2: decoded level from pulse length
        clr_mon(); host_pulse(4, 20);
        chk("R2", "rx count L=4", n_rx, 1); chk("R2", "rx one L=4", n_rx1, 1);
        clr_mon(); host_pulse(9, 20);
        chk("R2", "rx one L=9", n_rx1, 1);
        clr_mon(); host_pulse(10, 20);
        chk("R2", "rx count L=10", n_rx, 1); chk("R2", "rx one L=10", n_rx1, 0);
        clr_mon(); host_pulse(13, 20);
        chk("R2", "rx one L=13", n_rx1, 0);

        // R3: longest data bit and shortest SYNC
        clr_mon(); host_pulse(128, 20);
        chk("R3", "rx count L=128", n_rx, 1); chk("R3", "no sync L=128", n_low, 0);
        clr_mon();
        host_low = 1'b1;
        idle(729);
        chk("R3", "no rx on sync", n_rx, 0);
        chk("R4", "no soft reset in sync wait", n_soft, 0);
        host_low = 1'b0;
        idle(150);
        chk("R5", "sync answer low cycles", n_low, 128);
        chk("R5", "sync_done pulses", n_sd, 1);

        // R6: transmit zero
        clr_mon(); arm(1'b0); host_pulse(4, 30);
        chk("R6", "tx zero low cycles", n_low, 13);
        chk("R6", "speedup cycles", n_spd, 1);
        chk("R6", "no rx on tx", n_rx, 0);

        // R7: transmit one
        clr_mon(); arm(1'b1); host_pulse(4, 30);
        chk("R7", "tx one drive", n_low + n_spd, 0);
        chk("R7", "tx one no rx", n_rx, 0);
        clr_mon(); host_pulse(4, 20);
        chk("R7", "next bit received", n_rx, 1);

        // R8: timeout and discard of pending bit
        clr_mon(); idle(600);
        chk("R8", "soft reset after quiet", n_soft, 1);
        host_pulse(4, 10); arm(1'b0);
        clr_mon(); idle(600);
        chk("R8", "soft reset with pending", n_soft, 1);
        clr_mon(); host_pulse(4, 20);
        chk("R8", "discarded bit not driven", n_low, 0);
        chk("R8", "fall received as data", n_rx, 1);

        // R9: restarts inside the window
        clr_mon();
        for (int i = 0; i < 4; i++) host_pulse(4, 400);
        chk("R9", "no soft reset with activity", n_soft, 0);
        idle(200);
        chk("R9", "soft reset once quiet", n_soft, 1);

        // R10: no repeat without activity
        clr_mon(); idle(1500);
        chk("R10", "quiet after soft reset", n_soft, 0);
        chk("R11", "released while idle", int'(pin_oe), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule